// File: doc/BRIEF.md
# Serial Configuration Port with Status Reply

This block is a serial-peripheral slave that lets a host controller read and write a bank of byte-wide configuration registers. A transaction opens when chip select goes low. The first byte from the host is a header: a direction bit, a burst flag and a six-bit register address. After the header, one data byte follows, or a run of data bytes when the burst flag is set. In burst mode the address steps up by one after every data byte.

While the host shifts in bytes, the slave shifts a reply out on its serial output. For every header byte the reply is a status byte. Bit 7 is an active-low ready flag, bits 6:4 are the chip's main-state code, and bits 3:0 are a FIFO count that stops at 15. On a read, the count is the number of bytes waiting in the receive FIFO. On a write, it is the number of free places in the transmit FIFO. A write also returns a status byte for every data byte it accepts. A read instead returns the contents of the addressed register. The rest of the chip drives the ready flag, the state code and the two FIFO fill levels. The register contents leave the block on a flat output bus.

The controller runs on the system clock. It resynchronises the three serial pins and uses a five-state machine. SLV_IDLE waits for chip select, and on leaving it loads the status byte. SLV_HDR receives the header and moves to SLV_RDATA (direction bit 1) or SLV_WDATA (direction bit 0) on the eighth bit. SLV_WDATA and SLV_RDATA loop on themselves while the burst flag is set. Otherwise they move to SLV_IGNORE after one data byte. SLV_IGNORE stays put until the transaction ends. Chip select going high returns every state to SLV_IDLE.

Top module: `spi_reg_slave`

## Requirements
- R1: Bit 7 of each status byte carries `chip_rdy_n` as it was when that byte's slot began. For the header slot, that is the moment chip select is seen low.
- R2: Bits 6:4 of each status byte carry `main_state`, captured at the same moment as bit 7.
- R3: In a header whose bit 7 is 1 (read), status bits 3:0 equal `rx_fill` when `rx_fill` is below 15, and 15 otherwise.
- R4: In a header whose bit 7 is 0 (write), status bits 3:0 equal FIFO_DEPTH minus `tx_fill`, held at 15 when that difference is 15 or more. Both fill inputs never exceed FIFO_DEPTH.
- R5: Chip select is active low. Bits travel most significant first and are sampled on the rising SCLK edge, and the output changes after the falling edge. In the header, bit 7 is the direction (1 = read), bit 6 the burst flag and bits 5:0 the start address.
- R6: A write data byte at an address from 0x00 to 0x2F replaces that register, and the new value appears on `cfg_regs[8*a +: 8]`. All registers are 0x00 after reset.
- R7: A write data byte at an address from 0x30 to 0x3F leaves every register unchanged.
- R8: On a read, the byte after the header is the addressed register's content. An address from 0x30 to 0x3F returns 0x00.
- R9: With the burst flag set, each further data byte uses the address one above the previous one, wrapping from 0x3F to 0x00.
- R10: Without the burst flag, every byte after the first data byte is ignored, and the slave shifts out 0x00 during it.
- R11: `spi_miso` is 0 while chip select is high.
- R12: During each write data byte, the reply is a fresh status byte. It is formed as in R1, R2 and R4 from the inputs at the start of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| chip_rdy_n | input | 1 | Ready flag, low once supply and clock are stable |
| main_state | input | 3 | Main-state code of the chip |
| rx_fill | input | FILL_W (7) | Bytes held in the receive FIFO |
| tx_fill | input | FILL_W (7) | Bytes held in the transmit FIFO |
| cfg_regs | output | 8*NUM_REGS (384) | All configuration registers, register a at bits 8a+7:8a |

## Verification
The assertions assume that neither fill level rises above the FIFO depth; one property watches that input. They also assume the host keeps SCLK low when it drops chip select, and holds each SCLK phase for several system clocks so the resynchronised edges arrive in order. The stimulus holds each SCLK phase for eight system clocks and changes `spi_mosi` only on the falling edge. It changes the status inputs only while chip select is high. It sweeps both fill levels from zero to the full depth and steps the state code and ready flag through every value.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;

    // header byte layout: direction, burst, address
    typedef struct packed {
        logic       rd;
        logic       burst;
        logic [5:0] addr;
    } spi_hdr_t;

    localparam int HDR_ADDR_W = 6;

    typedef enum logic [2:0] {
        SLV_IDLE   = 3'd0,
        SLV_HDR    = 3'd1,
        SLV_WDATA  = 3'd2,
        SLV_RDATA  = 3'd3,
        SLV_IGNORE = 3'd4
    } slv_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
    logic              sclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p    <= '0;
            cs_p      <= '1;
            mosi_p    <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_p    <= {sclk_p[STAGES-2:0], sclk_in};
            cs_p      <= {cs_p[STAGES-2:0], cs_n_in};
            mosi_p    <= {mosi_p[STAGES-2:0], mosi_in};
            sclk_last <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_last;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_last;
    assign cs_act    = ~cs_p[STAGES-1];
    assign mosi_s    = mosi_p[STAGES-1];

endmodule

// File: rtl/spi_status_gen.sv
module spi_status_gen #(
    parameter int FIFO_DEPTH = 64,
    parameter int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              rdy_n,
    input  logic [2:0]        mstate,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic              dir_read,
    output logic [7:0]        status
);
    localparam logic [FILL_W-1:0] DEPTH_V = FILL_W'(FIFO_DEPTH);
    localparam logic [FILL_W-1:0] CAP_V   = FILL_W'(15);

    logic [FILL_W-1:0] tx_free;
    logic [FILL_W-1:0] pick;
    logic [3:0]        cnt;

    always_comb begin
        tx_free = DEPTH_V - tx_fill;
        pick    = dir_read ? rx_fill : tx_free;
        cnt     = (pick > CAP_V) ? 4'hF : pick[3:0];
        status  = {rdy_n, mstate, cnt};
    end

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
    parameter int NUM_REGS = 48,
    parameter int AW       = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [7:0]            wdata,
    input  logic [AW-1:0]         raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    logic [7:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= 8'h00;
            else if (we && waddr == AW'(i))
                regs_q[i] <= wdata;
        end
        assign cfg_flat[i*8 +: 8] = regs_q[i];
    end

    assign rdata = (int'(raddr) < NUM_REGS) ? regs_q[raddr] : 8'h00;

    // an accepted write lands in the addressed register
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(waddr) < NUM_REGS) |=> regs_q[$past(waddr)] == $past(wdata));

    // writes outside the bank leave every register alone
    assert_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(waddr) >= NUM_REGS) |=> $stable(cfg_flat));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_slave_pkg::*;
#(
    parameter int NUM_REGS    = 48,
    parameter int FIFO_DEPTH  = 64,
    parameter int FILL_W      = $clog2(FIFO_DEPTH + 1),
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_cs_n,
    input  logic                  spi_sclk,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    input  logic                  chip_rdy_n,
    input  logic [2:0]            main_state,
    input  logic [FILL_W-1:0]     rx_fill,
    input  logic [FILL_W-1:0]     tx_fill,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int AW = HDR_ADDR_W;

    slv_state_t state_q, state_d;

    logic          sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [2:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic [7:0]    nxt_data;
    logic          nxt_is_status;
    logic          hdr_rd, hdr_burst;
    logic [AW-1:0] addr_q;
    logic          byte_done;
    spi_hdr_t      rx_hdr;
    logic          dir_sel;
    logic [7:0]    status;
    logic          we;
    logic [AW-1:0] raddr;
    logic [7:0]    rdata;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    // while the header arrives its first bit picks the FIFO being counted
    assign dir_sel = (state_q == SLV_HDR) ? mosi_s : hdr_rd;

    spi_status_gen #(.FIFO_DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_stat (
        .rdy_n    (chip_rdy_n),
        .mstate   (main_state),
        .rx_fill  (rx_fill),
        .tx_fill  (tx_fill),
        .dir_read (dir_sel),
        .status   (status)
    );

    assign byte_done = sclk_rise && (bit_cnt == 3'd7);
    assign rx_hdr    = spi_hdr_t'({rx_sh, mosi_s});
    assign we        = byte_done && (state_q == SLV_WDATA);
    assign raddr     = (state_q == SLV_HDR) ? rx_hdr.addr : addr_q + AW'(1);

    spi_cfg_bank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .waddr    (addr_q),
        .wdata    ({rx_sh, mosi_s}),
        .raddr    (raddr),
        .rdata    (rdata),
        .cfg_flat (cfg_regs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLV_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = SLV_IDLE;
        end else begin
            unique case (state_q)
                SLV_IDLE:   state_d = SLV_HDR;
                SLV_HDR:    if (byte_done) state_d = rx_hdr.rd ? SLV_RDATA : SLV_WDATA;
                SLV_WDATA,
                SLV_RDATA:  if (byte_done && !hdr_burst) state_d = SLV_IGNORE;
                SLV_IGNORE: state_d = SLV_IGNORE;
                default:    state_d = SLV_IDLE;
            endcase
        end
    end

    // shift registers, header capture and reply selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt       <= 3'd0;
            rx_sh         <= 7'd0;
            tx_sh         <= 8'h00;
            nxt_data      <= 8'h00;
            nxt_is_status <= 1'b0;
            hdr_rd        <= 1'b0;
            hdr_burst     <= 1'b0;
            addr_q        <= '0;
        end else if (!cs_act) begin
            bit_cnt <= 3'd0;
            tx_sh   <= 8'h00;
        end else if (state_q == SLV_IDLE) begin
            bit_cnt <= 3'd0;
            tx_sh   <= status;
        end else if (sclk_rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (state_q == SLV_HDR && bit_cnt == 3'd0)
                tx_sh[3:0] <= status[3:0];
            if (byte_done) begin
                unique case (state_q)
                    SLV_HDR: begin
                        hdr_rd        <= rx_hdr.rd;
                        hdr_burst     <= rx_hdr.burst;
                        addr_q        <= rx_hdr.addr;
                        nxt_is_status <= ~rx_hdr.rd;
                        nxt_data      <= rdata;
                    end
                    SLV_WDATA: begin
                        addr_q        <= addr_q + AW'(1);
                        nxt_is_status <= hdr_burst;
                        nxt_data      <= 8'h00;
                    end
                    SLV_RDATA: begin
                        addr_q        <= addr_q + AW'(1);
                        nxt_is_status <= 1'b0;
                        nxt_data      <= hdr_burst ? rdata : 8'h00;
                    end
                    default: begin
                        nxt_is_status <= 1'b0;
                        nxt_data      <= 8'h00;
                    end
                endcase
            end
        end else if (sclk_fall) begin
            if (bit_cnt == 3'd0 && state_q != SLV_HDR)
                tx_sh <= nxt_is_status ? status : nxt_data;
            else
                tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign spi_miso = cs_act & tx_sh[7];

    // the header reply starts with the ready flag and state seen at select
    assert_hdr_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_IDLE && cs_act) |=>
            (tx_sh[7] == $past(chip_rdy_n) && tx_sh[6:4] == $past(main_state)));

    // the fill inputs stay within the FIFO depth
    assert_fill_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_fill) <= FIFO_DEPTH) && (int'(tx_fill) <= FIFO_DEPTH));

    // a completed header always leaves the header state
    assert_hdr_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_HDR && byte_done) |=>
            (state_q == SLV_RDATA || state_q == SLV_WDATA || state_q == SLV_IDLE));

    // burst steps the address by one after each data byte
    assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && hdr_burst && (state_q == SLV_WDATA || state_q == SLV_RDATA))
            |=> addr_q == $past(addr_q) + AW'(1));

    // once past the single data byte, nothing but zeros goes out
    assert_ignore_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_IGNORE && sclk_fall) |=> tx_sh == 8'h00);

    // no write strobe outside a write data slot
    assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_IGNORE || state_q == SLV_RDATA) |-> !we);

endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
    localparam int NUM_REGS = 48;
    localparam int DEPTH    = 64;
    localparam int FILL_W   = 7;
    localparam int HALF     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic chip_rdy_n = 1'b1;
    logic [2:0] main_state = 3'd0;
    logic [FILL_W-1:0] rx_fill = '0, tx_fill = '0;
    logic [NUM_REGS*8-1:0] cfg_regs;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] txb [0:63];
    logic [7:0] rxb [0:63];
    logic [7:0] model [0:NUM_REGS-1];

    always #10 clk = ~clk;

    spi_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .chip_rdy_n(chip_rdy_n),
        .main_state(main_state), .rx_fill(rx_fill), .tx_fill(tx_fill),
        .cfg_regs(cfg_regs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int stat_exp(input logic r, input logic [2:0] s, input int cnt);
        int c = (cnt > 15) ? 15 : cnt;
        return {24'd0, r, s, c[3:0]};
    endfunction

    task automatic spi_txn(input int n);
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            logic [7:0] r;
            for (int i = 7; i >= 0; i--) begin
                spi_mosi = txb[b][i];
                repeat (HALF) @(negedge clk);
                r[i] = spi_miso;
                spi_sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sclk = 1'b0;
            end
            rxb[b] = r;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic chk_bank(input string tag);
        for (int a = 0; a < NUM_REGS; a++)
            chk(tag, int'(cfg_regs[a*8 +: 8]), int'(model[a]));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int a = 0; a < NUM_REGS; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R11 idle miso", int'(spi_miso), 0);
        chk_bank("R6 reset value");

        // R3 read-header count sweep, with state code and ready flag varied
        for (int f = 0; f <= DEPTH; f++) begin
            rx_fill    = FILL_W'(f);
            tx_fill    = FILL_W'(DEPTH - f);
            main_state = 3'(f % 8);
            chip_rdy_n = f[4];
            txb[0] = 8'h80;
            txb[1] = 8'hFF;
            spi_txn(2);
            chk("R3 R1 R2 read header status", int'(rxb[0]),
                stat_exp(f[4], 3'(f % 8), f));
        end
        chk("R11 miso after select", int'(spi_miso), 0);

        // R4/R12 write-header and write-data status sweep, writes to 0x30 ignored
        for (int f = 0; f <= DEPTH; f++) begin
            tx_fill    = FILL_W'(f);
            rx_fill    = FILL_W'(DEPTH - f);
            main_state = 3'(7 - (f % 8));
            chip_rdy_n = f[3];
            txb[0] = 8'h30;
            txb[1] = 8'hAA;
            spi_txn(2);
            chk("R4 write header status", int'(rxb[0]),
                stat_exp(f[3], 3'(7 - (f % 8)), DEPTH - f));
            chk("R12 write data status", int'(rxb[1]),
                stat_exp(f[3], 3'(7 - (f % 8)), DEPTH - f));
        end
        chk_bank("R7 writes above 0x2F");

        // R6/R9 burst write of the whole bank
        chip_rdy_n = 1'b0; main_state = 3'd2; tx_fill = 7'd20; rx_fill = 7'd3;
        txb[0] = 8'h40;
        for (int a = 0; a < NUM_REGS; a++) begin
            txb[a+1] = 8'((a * 37 + 5) & 8'hFF);
            model[a] = txb[a+1];
        end
        spi_txn(NUM_REGS + 1);
        for (int a = 0; a <= NUM_REGS; a++)
            chk("R12 burst write status", int'(rxb[a]), stat_exp(1'b0, 3'd2, DEPTH - 20));
        chk_bank("R6 R9 burst write");

        // R8 single reads over every address
        for (int a = 0; a < 64; a++) begin
            txb[0] = 8'(8'h80 | a);
            txb[1] = 8'h00;
            spi_txn(2);
            chk("R5 R8 single read", int'(rxb[1]), (a < NUM_REGS) ? int'(model[a]) : 0);
        end

        // R7 single write above the bank
        txb[0] = 8'h35; txb[1] = 8'h99;
        spi_txn(2);
        chk_bank("R7 write to 0x35");

        // R10 non-burst write with trailing bytes
        main_state = 3'd3; tx_fill = 7'd60;
        txb[0] = 8'h10; txb[1] = 8'h5A; txb[2] = 8'hC3; txb[3] = 8'h77;
        spi_txn(4);
        model[16] = 8'h5A;
        chk("R12 single write data status", int'(rxb[1]), stat_exp(1'b0, 3'd3, 4));
        chk("R10 trailing byte zero", int'(rxb[2]), 0);
        chk("R10 trailing byte zero", int'(rxb[3]), 0);
        chk_bank("R10 only first byte written");

        // R10 non-burst read with trailing bytes
        txb[0] = 8'h85; txb[1] = 8'h00; txb[2] = 8'h00;
        spi_txn(3);
        chk("R8 read 0x05", int'(rxb[1]), int'(model[5]));
        chk("R10 read trailing zero", int'(rxb[2]), 0);

        // R8/R9 burst read crossing the end of the bank and the address wrap
        rx_fill = 7'd9;
        txb[0] = 8'hEE;
        for (int k = 1; k <= 4; k++) txb[k] = 8'h00;
        spi_txn(5);
        chk("R3 burst read header", int'(rxb[0]), stat_exp(1'b0, 3'd3, 9));
        chk("R9 burst read 0x2E", int'(rxb[1]), int'(model[46]));
        chk("R9 burst read 0x2F", int'(rxb[2]), int'(model[47]));
        chk("R8 burst read 0x30", int'(rxb[3]), 0);
        chk("R8 burst read 0x31", int'(rxb[4]), 0);
        txb[0] = 8'hFE;
        spi_txn(5);
        chk("R8 burst read 0x3E", int'(rxb[1]), 0);
        chk("R8 burst read 0x3F", int'(rxb[2]), 0);
        chk("R9 burst read wrap 0x00", int'(rxb[3]), int'(model[0]));
        chk("R9 burst read wrap 0x01", int'(rxb[4]), int'(model[1]));

        // R9 burst write wrapping from 0x3F to 0x00
        txb[0] = 8'h7F; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
        spi_txn(4);
        model[0] = 8'h22; model[1] = 8'h33;
        chk_bank("R9 burst write wrap");
        chk("R11 miso at end", int'(spi_miso), 0);

        done = 1'b1;
        finish_run();
    end

endmodule